// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Aggregator

This block gathers a vector of interrupt condition inputs and reduces them to one interrupt pin. Each source has a 2-bit trigger mode and an enable bit. The mode selects whether the source fires on the condition appearing, on the condition going away, or for as long as the condition is present. The enable bit decides whether the source may touch the status register and the pin at all. The conditions arrive from unrelated logic, so each one passes through a two-stage synchroniser before any edge is detected.

Software reaches the block through a plain register port. A write strobe, a read strobe, an address and a data word give access to two mode-bit registers (upper and lower bit of each source's code), the enable register and the status register. Reading the status register clears the sticky edge bits. A separate 2-bit pin-select input chooses how the aggregate request appears on the pin: driven high, driven low, or low with drive released when idle.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the upper-mode, lower-mode, enable and status registers all read zero and no request is signalled on the pin.
- R2: Address 0 holds the upper mode bit and address 1 the lower mode bit of every source, with source i at bit i. Address 2 holds the enable bits. Each address reads back the value last written.
- R3: Mode code {upper,lower}=00 (rising): a 0-to-1 change on a condition sets its status bit three clock edges after the input changes. The bit stays set after the condition returns to 0, until a status read.
- R4: Mode code 01 (falling): a 1-to-0 change on a condition sets its status bit with the same three-edge latency, and the bit is sticky in the same way.
- R5: Mode code 10 (level): the status bit equals the condition delayed by three edges, on every cycle, without needing a read.
- R6: Mode code 11 is reserved and never sets the status bit. A source in this mode has its status bit cleared on the next edge.
- R7: A source whose enable bit is 0 never sets its status bit and never drives the pin.
- R8: A read strobe at address 3 returns the status register and clears every edge-mode (rising or falling) status bit at the next edge.
- R9: An edge on an enabled edge-mode source that is detected in the same cycle as a status read leaves that status bit set.
- R10: The request is the OR of status bits whose enable bit is set. Pin select 00 or 11 drives the pin high on request. Select 01 drives it low on request. Select 10 keeps the level at 0 and turns the output enable on only while a request is present; in every other select the enable is always 1.
- R11: Writes to address 3 have no effect on the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_i | input | N_SRC | Asynchronous interrupt condition per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status on address 3) |
| addr | input | 2 | Register address: 0 upper mode, 1 lower mode, 2 enable, 3 status |
| wdata | input | N_SRC | Write data |
| rdata | output | N_SRC | Read data of the addressed register |
| pin_sel | input | 2 | Pin drive select |
| int_o | output | 1 | Interrupt pin level |
| int_oe | output | 1 | Interrupt pin output enable |

## Verification
A corrupted status bit shows up at the pin in the same cycle, because the pin logic is combinational from the status and enable registers. It also appears on rdata the next time address 3 is addressed. A wrong synchroniser depth or a wrong edge detector moves the set point away from the third edge after a condition change, and a bench that compares every cycle sees this at once. A read clear that loses a simultaneous edge, or a disabled source that leaks into status, shows up in the read data one cycle after the event.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [1:0] {
    TRIG_RISE  = 2'b00,
    TRIG_FALL  = 2'b01,
    TRIG_LEVEL = 2'b10,
    TRIG_RSVD  = 2'b11
  } trig_mode_e;

  typedef enum logic [1:0] {
    PIN_HIGH  = 2'b00,
    PIN_LOW   = 2'b01,
    PIN_OPEN  = 2'b10,
    PIN_SPARE = 2'b11
  } pin_sel_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_MODE_HI = 2'd0;
  localparam logic [ADDR_W-1:0] A_MODE_LO = 2'd1;
  localparam logic [ADDR_W-1:0] A_ENABLE  = 2'd2;
  localparam logic [ADDR_W-1:0] A_STATUS  = 2'd3;

  // Edge hit for one source given its mode and detected edges.
  function automatic logic trig_hit(input trig_mode_e m, input logic rise, input logic fall);
    case (m)
      TRIG_RISE: trig_hit = rise;
      TRIG_FALL: trig_hit = fall;
      default:   trig_hit = 1'b0;
    endcase
  endfunction

  // Next status bit for one source.
  function automatic logic stat_next(input trig_mode_e m, input logic cur, input logic hit,
                                     input logic lvl, input logic en, input logic clr);
    case (m)
      TRIG_RISE, TRIG_FALL: stat_next = (cur & ~clr) | (hit & en);
      TRIG_LEVEL:           stat_next = lvl & en;
      default:              stat_next = 1'b0;
    endcase
  endfunction

  // Pin drive: returns {level, output_enable}.
  function automatic logic [1:0] pin_drive(input pin_sel_e s, input logic req);
    case (s)
      PIN_LOW:  pin_drive = {~req, 1'b1};
      PIN_OPEN: pin_drive = {1'b0, req};
      default:  pin_drive = {req, 1'b1};
    endcase
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_status.sv
module irq_status
  import irq_agg_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] cond_s,
  input  logic [N_SRC-1:0] mode_hi,
  input  logic [N_SRC-1:0] mode_lo,
  input  logic [N_SRC-1:0] enable,
  input  logic             clr,
  output logic [N_SRC-1:0] status,
  output logic [N_SRC-1:0] edge_hit
);
  logic [N_SRC-1:0] cond_d;
  logic [N_SRC-1:0] rise_w;
  logic [N_SRC-1:0] fall_w;
  logic [N_SRC-1:0] stat_nxt;

  always_ff @(posedge clk) begin
    if (rst) cond_d <= '0;
    else     cond_d <= cond_s;
  end

  assign rise_w = cond_s & ~cond_d;
  assign fall_w = ~cond_s & cond_d;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    trig_mode_e m;
    assign m           = trig_mode_e'({mode_hi[i], mode_lo[i]});
    assign edge_hit[i] = trig_hit(m, rise_w[i], fall_w[i]);
    assign stat_nxt[i] = stat_next(m, status[i], edge_hit[i], cond_s[i], enable[i], clr);
  end

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= stat_nxt;
  end
endmodule

// File: rtl/irq_pin.sv
module irq_pin
  import irq_agg_pkg::*;
(
  input  logic       req,
  input  logic [1:0] pin_sel,
  output logic       int_o,
  output logic       int_oe
);
  logic [1:0] drv;
  assign drv    = pin_drive(pin_sel_e'(pin_sel), req);
  assign int_o  = drv[1];
  assign int_oe = drv[0];
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  cond_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [N_SRC-1:0]  wdata,
  output logic [N_SRC-1:0]  rdata,
  input  logic [1:0]        pin_sel,
  output logic              int_o,
  output logic              int_oe
);
  localparam int SYNC_STAGES = 2;

  logic [N_SRC-1:0] mode_hi_q, mode_lo_q, enable_q;
  logic [N_SRC-1:0] cond_s, status, edge_hit;
  logic             rd_stat;
  logic             req;

  irq_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(cond_i), .q_o(cond_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_hi_q <= '0;
      mode_lo_q <= '0;
      enable_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_MODE_HI: mode_hi_q <= wdata;
        A_MODE_LO: mode_lo_q <= wdata;
        A_ENABLE:  enable_q  <= wdata;
        default:   ;
      endcase
    end
  end

  assign rd_stat = rd_en && (addr == A_STATUS);

  irq_status #(.N_SRC(N_SRC)) u_stat (
    .clk(clk), .rst(rst), .cond_s(cond_s), .mode_hi(mode_hi_q), .mode_lo(mode_lo_q),
    .enable(enable_q), .clr(rd_stat), .status(status), .edge_hit(edge_hit)
  );

  always_comb begin
    case (addr)
      A_MODE_HI: rdata = mode_hi_q;
      A_MODE_LO: rdata = mode_lo_q;
      A_ENABLE:  rdata = enable_q;
      default:   rdata = status;
    endcase
  end

  assign req = |(status & enable_q);

  irq_pin u_pin (.req(req), .pin_sel(pin_sel), .int_o(int_o), .int_oe(int_oe));
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int N_SRC = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_stat,
  input logic [N_SRC-1:0] mode_hi,
  input logic [N_SRC-1:0] mode_lo,
  input logic [N_SRC-1:0] enable,
  input logic [N_SRC-1:0] status,
  input logic [N_SRC-1:0] edge_hit,
  input logic [N_SRC-1:0] cond_s,
  input logic [1:0]       pin_sel,
  input logic             int_o,
  input logic             int_oe
);
  // R3/R4: edge-mode bits stay set when nothing reads them
  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_stat |=> (($past(status & ~mode_hi) & ~status) == '0));

  // R5: level bits track the enabled synchronised condition
  p_level_track_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((status ^ $past(cond_s & enable)) & $past(mode_hi & ~mode_lo)) == '0));

  // R6: reserved mode never leaves a bit set
  p_reserved_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    ((mode_hi & mode_lo) != '0) |=> ((status & $past(mode_hi & mode_lo)) == '0));

  // R7: newly set bits always belong to enabled sources
  p_masked_silent_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & ~$past(status) & ~$past(enable)) == '0));

  // R8: read clears edge bits that had no hit
  p_read_clear_r8: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> ((status & $past(~mode_hi & ~edge_hit)) == '0));

  // R9: a hit coinciding with a read survives
  p_edge_wins_r9: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> ((status & $past(edge_hit & enable & ~mode_hi)) == $past(edge_hit & enable & ~mode_hi)));

  // R10: open-drain select never drives the level high
  p_open_low_r10: assert property (@(posedge clk) disable iff (rst)
    (pin_sel == 2'b10) |-> (int_o == 1'b0));

  // R10: push-pull selects always drive
  p_push_drive_r10: assert property (@(posedge clk) disable iff (rst)
    (pin_sel != 2'b10) |-> int_oe);

  // R10: active-high pin reflects enabled status
  p_high_req_r10: assert property (@(posedge clk) disable iff (rst)
    (pin_sel == 2'b00) |-> (int_o == |(status & enable)));
endmodule

bind irq_aggregator irq_aggregator_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst(rst), .rd_stat(rd_stat), .mode_hi(mode_hi_q), .mode_lo(mode_lo_q),
  .enable(enable_q), .status(status), .edge_hit(edge_hit), .cond_s(cond_s),
  .pin_sel(pin_sel), .int_o(int_o), .int_oe(int_oe)
);

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] cond_i;
  logic         wr_en, rd_en;
  logic [1:0]   addr;
  logic [N-1:0] wdata;
  logic [N-1:0] rdata;
  logic [1:0]   pin_sel;
  logic         int_o, int_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Bench-side model state
  logic [N-1:0] m_hi, m_lo, m_en, m_st, p1, p2, pd;

  irq_aggregator #(.N_SRC(N)) u0 (
    .clk(clk), .rst(rst), .cond_i(cond_i), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_sel(pin_sel), .int_o(int_o), .int_oe(int_oe)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] ref_pin(input logic [1:0] s, input logic r);
    if (s == 2'b01)      return {~r, 1'b1};
    else if (s == 2'b10) return {1'b0, r};
    else                 return {r, 1'b1};
  endfunction

  function automatic logic [N-1:0] ref_reg(input logic [1:0] a);
    case (a)
      2'd0: return m_hi;
      2'd1: return m_lo;
      2'd2: return m_en;
      default: return m_st;
    endcase
  endfunction

  // Model one clock edge from the values driven before it.
  task automatic model_edge();
    logic [N-1:0] nst;
    for (int i = 0; i < N; i++) begin
      logic r, f;
      r = p2[i] & ~pd[i];
      f = ~p2[i] & pd[i];
      case ({m_hi[i], m_lo[i]})
        2'b00: nst[i] = (m_st[i] & ~(rd_en && addr == 2'd3)) | (r & m_en[i]);
        2'b01: nst[i] = (m_st[i] & ~(rd_en && addr == 2'd3)) | (f & m_en[i]);
        2'b10: nst[i] = p2[i] & m_en[i];
        default: nst[i] = 1'b0;
      endcase
    end
    m_st = nst;
    if (wr_en) begin
      if (addr == 2'd0) m_hi = wdata;
      if (addr == 2'd1) m_lo = wdata;
      if (addr == 2'd2) m_en = wdata;
    end
    pd = p2; p2 = p1; p1 = cond_i;
  endtask

  // One cycle: inputs already set at negedge; check read data, step, check pin.
  task automatic step(input string req);
    #1;
    check({req, " rdata"}, rdata, ref_reg(addr));
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check({req, " pin"}, {6'b0, int_o, int_oe}, {6'b0, ref_pin(pin_sel, |(m_st & m_en))});
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d, input string req);
    wr_en = 1; addr = a; wdata = d; step(req);
  endtask

  task automatic rd(input logic [1:0] a, input string req);
    rd_en = 1; addr = a; step(req);
  endtask

  task automatic idle(input int n, input string req);
    for (int k = 0; k < n; k++) begin addr = 2'd3; step(req); end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] tmp;
    void'($urandom(32'h1A2B3C));
    rst = 1; cond_i = '0; wr_en = 0; rd_en = 0; addr = 2'd3; wdata = '0; pin_sel = 2'b00;
    m_hi = '0; m_lo = '0; m_en = '0; m_st = '0; p1 = '0; p2 = '0; pd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin addr = a[1:0]; #1; check("R1 reset reg", rdata, '0); end
    check("R1 reset pin", {6'b0, int_o, int_oe}, 8'b01);

    // R2: readback
    wr(2'd0, 8'hA5, "R2"); wr(2'd1, 8'h3C, "R2"); wr(2'd2, 8'hF0, "R2");
    addr = 2'd0; #1; check("R2 hi", rdata, 8'hA5);
    addr = 2'd1; #1; check("R2 lo", rdata, 8'h3C);
    addr = 2'd2; #1; check("R2 en", rdata, 8'hF0);

    // R11: status write ignored
    wr(2'd3, 8'hFF, "R11"); addr = 2'd3; #1; check("R11 status unchanged", rdata, '0);

    // R3: rising mode, exact latency
    wr(2'd0, 8'h00, "R3"); wr(2'd1, 8'h00, "R3"); wr(2'd2, 8'h01, "R3");
    cond_i = 8'h01; idle(2, "R3");
    addr = 2'd3; #1; check("R3 not yet after two edges", rdata, 8'h00);
    idle(1, "R3"); #1; check("R3 set after third edge", rdata, 8'h01);
    cond_i = 8'h00; idle(4, "R3"); #1; check("R3 sticky", rdata, 8'h01);
    rd(2'd3, "R8"); #1; check("R8 cleared after read", rdata, 8'h00);

    // R4: falling mode
    wr(2'd1, 8'h02, "R4"); wr(2'd2, 8'h02, "R4");
    cond_i = 8'h02; idle(4, "R4"); #1; check("R4 no set on rise", rdata, 8'h00);
    cond_i = 8'h00; idle(3, "R4"); #1; check("R4 set on fall", rdata, 8'h02);
    rd(2'd3, "R8");

    // R5: level mode
    wr(2'd0, 8'h04, "R5"); wr(2'd1, 8'h00, "R5"); wr(2'd2, 8'h04, "R5");
    cond_i = 8'h04; idle(3, "R5"); #1; check("R5 level on", rdata, 8'h04);
    cond_i = 8'h00; idle(3, "R5"); #1; check("R5 level off", rdata, 8'h00);

    // R6: reserved mode
    wr(2'd0, 8'h08, "R6"); wr(2'd1, 8'h08, "R6"); wr(2'd2, 8'h08, "R6");
    cond_i = 8'h08; idle(4, "R6"); cond_i = 8'h00; idle(4, "R6");
    #1; check("R6 reserved quiet", rdata, 8'h00);

    // R7: masked source, with the pin in active-high
    wr(2'd0, 8'h00, "R7"); wr(2'd1, 8'h00, "R7"); wr(2'd2, 8'h00, "R7");
    cond_i = 8'hFF; idle(4, "R7"); #1; check("R7 masked status", rdata, 8'h00);
    check("R7 masked pin", {7'b0, int_o}, 8'h00);
    cond_i = 8'h00; idle(3, "R7");

    // R9: edge coinciding with read
    wr(2'd2, 8'h10, "R9");
    cond_i = 8'h10; idle(2, "R9");
    rd(2'd3, "R9"); #1; check("R9 edge kept", rdata, 8'h10);
    rd(2'd3, "R8"); #1; check("R8 clear", rdata, 8'h00);

    // R10: pin selects with a pending request
    cond_i = 8'h00; idle(3, "R10"); cond_i = 8'h10; idle(3, "R10");
    for (int s = 0; s < 4; s++) begin
      pin_sel = s[1:0]; #1;
      check("R10 pin", {6'b0, int_o, int_oe}, {6'b0, ref_pin(s[1:0], 1'b1)});
    end
    rd(2'd3, "R10");
    for (int s = 0; s < 4; s++) begin
      pin_sel = s[1:0]; #1;
      check("R10 idle pin", {6'b0, int_o, int_oe}, {6'b0, ref_pin(s[1:0], 1'b0)});
    end

    // Random phase, all requirements against the model
    for (int k = 0; k < 3000; k++) begin
      tmp = N'($urandom);
      cond_i = ($urandom % 4 == 0) ? tmp : cond_i;
      pin_sel = 2'($urandom);
      addr = 2'($urandom);
      wdata = N'($urandom);
      case ($urandom % 8)
        0: wr_en = 1;
        1, 2: rd_en = 1;
        default: ;
      endcase
      step("R3/R4/R5/R6/R7/R8 random");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule